// File: doc/BRIEF.md
# Local Interrupt Vector Table Dispatcher

This block sits between six on-core interrupt sources and the interrupt request tracker. Each source (timer, thermal sensor, performance counter, local pin 0, local pin 1 and internal error) owns one 32-bit vector table entry. The entry holds the vector number to raise, a delivery-mode code, a mask bit and, for the timer, a one-shot/periodic mode bit. Software writes and reads the entries through a simple indexed register port.

When a source event arrives, it is latched as pending. One pending source is served per cycle, in a fixed priority order. Serving reads the source's entry at that moment and applies two rules. A masked entry drops the event silently. An unmasked entry either forwards its vector as a one-cycle raise strobe or, if the delivery mode is not fixed, refuses it and sets a sticky error flag. The timer and error sources always deliver as fixed, whatever their mode field holds. Any register write clears the flag.

Top module: `lvt_dispatch`

## Requirements
- R1: After reset every entry at index 0..5 reads 0x00010000 (masked, vector 0). Index 6 and index 7 read 0. `raise_vld_o` and `mode_err_o` are low.
- R2: A write with `reg_sel_i` in 0..5 stores all 32 bits of `reg_wdata_i` into that entry. `reg_rdata_o` shows the selected entry combinationally from the following cycle. Indexes are timer 0, thermal 1, performance 2, pin0 3, pin1 4, error 5. Writes to index 6 or 7 change no entry, and those indexes always read 0. Field layout: vector [7:0], delivery mode [10:8], mask bit 16, timer mode bit 17 (stored only).
- R3: An event on a source whose entry has bit 16 set produces no raise strobe and leaves `mode_err_o` unchanged.
- R4: Timer (index 0) and error (index 5) events on unmasked entries raise their vector whatever bits [10:8] hold. This includes codes 2, 4, 5 and 7.
- R5: An unmasked event on index 1..4 with mode code 0 (fixed) raises the entry's bits [7:0]. `raise_vld_o` is high for one cycle after the clock edge that samples the event, and `raise_vec_o` carries the vector in that same cycle.
- R6: An unmasked event on index 1..4 with any non-zero mode code (2 SMI, 4 NMI, 5 INIT, 7 external controller, or the unused codes) produces no raise. It sets `mode_err_o` at the edge where that source is served.
- R7: `mode_err_o` stays high until a register write to any index. If a refusal and a write fall on the same edge, the flag ends up set.
- R8: Sources pending together are served one per cycle, lowest index first, with one strobe per served unmasked fixed source.
- R9: A repeated event on a source that is still pending merges with the pending one and yields a single raise.
- R10: The mask, mode and vector are taken from the entry when the source is served, not when its event arrived. A rewrite that lands before the serve edge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write enable |
| reg_sel_i | input | 3 | Entry index for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Selected entry contents |
| event_i | input | 6 | Per-source event pulses, bit n = index n |
| raise_vld_o | output | 1 | One-cycle raise strobe to the request tracker |
| raise_vec_o | output | 8 | Vector carried with the strobe |
| mode_err_o | output | 1 | Sticky unsupported-delivery-mode flag |

## Verification
The hardest situation to reach is one where the serve order itself matters. Several sources must be pending at once, one of them must fire again while still queued, and an entry must be rewritten between the event and its serve. The stimulus fires all six sources in one cycle and re-fires the lowest-priority one during the drain. It also lands a write to a queued source's entry on the same edge as the events, so the later serve must show the new vector. A refused event coinciding with a write checks which of set and clear wins on the error flag.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int NSRC      = 6;
  localparam int DW        = 32;
  localparam int VW        = 8;
  localparam int MODE_LSB  = 8;
  localparam int MODE_W    = 3;
  localparam int MASK_BIT  = 16;
  localparam int TMODE_BIT = 17;

  localparam logic [DW-1:0] ENTRY_RST = 32'h0001_0000;

  // sources that deliver as fixed regardless of their mode field
  localparam logic [NSRC-1:0] FORCE_FIXED = 6'b10_0001;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'h0,
    DM_SMI    = 3'h2,
    DM_NMI    = 3'h4,
    DM_INIT   = 3'h5,
    DM_EXTINT = 3'h7
  } dmode_e;
endpackage

// File: rtl/lvt_entry_bank.sv
module lvt_entry_bank #(
  parameter int              N     = 6,
  parameter int              W     = 32,
  parameter int              SEL_W = 3,
  parameter logic [W-1:0]    RST   = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [W-1:0]          wdata_i,
  output logic [N-1:0][W-1:0]   entry_o,
  output logic [W-1:0]          rdata_o
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           entry_o[g] <= RST;
      else if (wr_i && sel_i == SEL_W'(g))   entry_o[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (sel_i == SEL_W'(i)) rdata_o = entry_o[i];
  end
endmodule

// File: rtl/lvt_prio_pick.sv
module lvt_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lvt_deliver_gate.sv
module lvt_deliver_gate
  import lvt_pkg::*;
#(
  parameter int              N     = 6,
  parameter int              W     = 32,
  parameter int              VECW  = 8,
  parameter logic [N-1:0]    FORCE = '0
) (
  input  logic [N-1:0][W-1:0] entry_i,
  input  logic [N-1:0]        gnt_i,
  output logic                fwd_o,
  output logic                refuse_o,
  output logic [VECW-1:0]     vec_o
);
  logic [W-1:0]      sel_entry;
  logic              any_gnt, masked, forced, is_fixed;
  logic [MODE_W-1:0] mode;

  always_comb begin
    sel_entry = '0;
    for (int i = 0; i < N; i++)
      if (gnt_i[i]) sel_entry = sel_entry | entry_i[i];
  end

  assign any_gnt  = |gnt_i;
  assign forced   = |(gnt_i & FORCE);
  assign masked   = sel_entry[MASK_BIT];
  assign mode     = sel_entry[MODE_LSB +: MODE_W];
  assign is_fixed = (mode == DM_FIXED);
  assign vec_o    = sel_entry[VECW-1:0];

  assign fwd_o    = any_gnt && !masked && (forced || is_fixed);
  assign refuse_o = any_gnt && !masked && !forced && !is_fixed;
endmodule

// File: rtl/lvt_dispatch.sv
module lvt_dispatch
  import lvt_pkg::*;
#(
  parameter int                 NSRC_P = lvt_pkg::NSRC,
  parameter int                 DW_P   = lvt_pkg::DW,
  parameter int                 VW_P   = lvt_pkg::VW,
  parameter logic [NSRC_P-1:0]  FORCE_P = lvt_pkg::FORCE_FIXED,
  localparam int                SEL_W  = $clog2(NSRC_P + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [DW_P-1:0]   reg_wdata_i,
  output logic [DW_P-1:0]   reg_rdata_o,
  input  logic [NSRC_P-1:0] event_i,
  output logic              raise_vld_o,
  output logic [VW_P-1:0]   raise_vec_o,
  output logic              mode_err_o
);
  logic [NSRC_P-1:0][DW_P-1:0] entry;
  logic [NSRC_P-1:0] pend_q, req, gnt;
  logic              fwd, refuse;
  logic [VW_P-1:0]   vec;

  lvt_entry_bank #(
    .N(NSRC_P), .W(DW_P), .SEL_W(SEL_W), .RST(ENTRY_RST)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .entry_o (entry),
    .rdata_o (reg_rdata_o)
  );

  assign req = pend_q | event_i;

  lvt_prio_pick #(.N(NSRC_P)) u_pick (
    .req_i (req),
    .gnt_o (gnt)
  );

  lvt_deliver_gate #(
    .N(NSRC_P), .W(DW_P), .VECW(VW_P), .FORCE(FORCE_P)
  ) u_gate (
    .entry_i  (entry),
    .gnt_i    (gnt),
    .fwd_o    (fwd),
    .refuse_o (refuse),
    .vec_o    (vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      raise_vld_o <= 1'b0;
      raise_vec_o <= '0;
      mode_err_o  <= 1'b0;
    end else begin
      pend_q      <= req & ~gnt;
      raise_vld_o <= fwd;
      if (fwd) raise_vec_o <= vec;
      // set outranks the clearing write
      if (refuse)        mode_err_o <= 1'b1;
      else if (reg_wr_i) mode_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lvt_dispatch_chk.sv
module lvt_dispatch_chk #(
  parameter int N     = 6,
  parameter int DW    = 32,
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [SEL_W-1:0] reg_sel_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic [N-1:0]     event_i,
  input logic [N-1:0]     pend_q,
  input logic [N-1:0]     gnt,
  input logic             raise_vld_o,
  input logic             mode_err_o
);
  assert_wr_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i < SEL_W'(N)) |=>
      (reg_sel_i != $past(reg_sel_i) || reg_rdata_o == $past(reg_wdata_i)));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_err_o && !reg_wr_i) |=> mode_err_o);

  assert_one_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  assert_raise_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_vld_o |-> $past(|(pend_q | event_i)));

  assert_err_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_err_o) |-> $past(|(pend_q | event_i)));

  assert_no_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_vld_o |-> !$rose(mode_err_o));

  assert_pend_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~gnt) != '0) |=>
      ((pend_q & $past(pend_q & ~gnt)) == $past(pend_q & ~gnt)));
endmodule

bind lvt_dispatch lvt_dispatch_chk #(
  .N(NSRC_P), .DW(DW_P), .SEL_W(SEL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .event_i     (event_i),
  .pend_q      (pend_q),
  .gnt         (gnt),
  .raise_vld_o (raise_vld_o),
  .mode_err_o  (mode_err_o)
);

// File: tb/lvt_dispatch_tb_top.sv
module lvt_dispatch_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [5:0]  event_i = '0;
  logic        raise_vld_o;
  logic [7:0]  raise_vec_o;
  logic        mode_err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  lvt_dispatch dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .event_i(event_i),
    .raise_vld_o(raise_vld_o), .raise_vec_o(raise_vec_o),
    .mode_err_o(mode_err_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] val);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = val;
    cyc();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(string req, input logic [2:0] sel, input logic [31:0] exp);
    reg_sel_i = sel;
    #1;
    check(req, "readback", reg_rdata_o, exp);
  endtask

  // fire events for one cycle; returns after the sampling edge
  task automatic fire(input logic [5:0] ev);
    event_i = ev;
    cyc();
    event_i = '0;
  endtask

  task automatic expect_raise(string req, input logic [7:0] vec);
    check(req, "raise_vld", {31'b0, raise_vld_o}, 32'd1);
    if (raise_vld_o) check(req, "raise_vec", {24'b0, raise_vec_o}, {24'b0, vec});
  endtask

  task automatic expect_quiet(string req, input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      check(req, "no raise", {31'b0, raise_vld_o}, 32'd0);
      cyc();
    end
  endtask

  task automatic t_reset();
    check("R1", "raise after reset", {31'b0, raise_vld_o}, 32'd0);
    check("R1", "err after reset", {31'b0, mode_err_o}, 32'd0);
    for (int i = 0; i < 6; i++) rd_chk("R1", 3'(i), 32'h0001_0000);
    rd_chk("R1", 3'd6, 32'h0);
    rd_chk("R1", 3'd7, 32'h0);
  endtask

  task automatic t_masked();
    // all entries still masked from reset
    fire(6'b11_1111);
    expect_quiet("R3", 8);
    check("R3", "err after masked", {31'b0, mode_err_o}, 32'd0);
    // masked with a bad mode: still no error
    wr(3'd2, 32'h0001_0455);
    fire(6'b00_0100);
    expect_quiet("R3", 2);
    check("R3", "err masked bad mode", {31'b0, mode_err_o}, 32'd0);
  endtask

  task automatic t_regs();
    for (int i = 0; i < 6; i++) wr(3'(i), 32'hA5A3_0000 | 32'(i * 17));
    for (int i = 0; i < 6; i++) rd_chk("R2", 3'(i), 32'hA5A3_0000 | 32'(i * 17));
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h1234_5678);
    rd_chk("R2", 3'd6, 32'h0);
    rd_chk("R2", 3'd7, 32'h0);
    for (int i = 0; i < 6; i++) rd_chk("R2", 3'(i), 32'hA5A3_0000 | 32'(i * 17));
    wr(3'd0, 32'h0002_0000);
    rd_chk("R2", 3'd0, 32'h0002_0000);
  endtask

  task automatic t_forced();
    wr(3'd0, 32'h0002_0731);   // periodic, mode 7, vector 0x31
    wr(3'd5, 32'h0000_02A5);   // mode 2, vector 0xA5
    fire(6'b00_0001);
    expect_raise("R4", 8'h31);
    cyc();
    check("R4", "strobe one cycle", {31'b0, raise_vld_o}, 32'd0);
    fire(6'b10_0000);
    expect_raise("R4", 8'hA5);
    wr(3'd5, 32'h0000_05B6);
    fire(6'b10_0000);
    expect_raise("R4", 8'hB6);
    check("R4", "no err forced", {31'b0, mode_err_o}, 32'd0);
    cyc();
  endtask

  task automatic t_fixed();
    for (int i = 1; i <= 4; i++) wr(3'(i), 32'h40 + 32'(i));
    for (int i = 1; i <= 4; i++) begin
      fire(6'(1 << i));
      expect_raise("R5", 8'(8'h40 + i));
      cyc();
      check("R5", "strobe drops", {31'b0, raise_vld_o}, 32'd0);
    end
    check("R5", "no err fixed", {31'b0, mode_err_o}, 32'd0);
  endtask

  task automatic t_refuse();
    logic [2:0] modes [4] = '{3'h5, 3'h4, 3'h2, 3'h7};
    for (int i = 1; i <= 4; i++) begin
      wr(3'(i), {21'b0, modes[i-1], 8'h60 + 8'(i)});
      check("R7", "cleared by write", {31'b0, mode_err_o}, 32'd0);
      fire(6'(1 << i));
      check("R6", "no raise refused", {31'b0, raise_vld_o}, 32'd0);
      check("R6", "err set", {31'b0, mode_err_o}, 32'd1);
      cyc();
    end
  endtask

  task automatic t_sticky();
    expect_quiet("R7", 5);
    check("R7", "err holds", {31'b0, mode_err_o}, 32'd1);
    wr(3'd7, 32'h0);
    check("R7", "write clears", {31'b0, mode_err_o}, 32'd0);
    // refusal and write on the same edge: set wins
    reg_wr_i = 1'b1; reg_sel_i = 3'd6; reg_wdata_i = '0;
    event_i = 6'b01_0000;
    cyc();
    reg_wr_i = 1'b0; event_i = '0;
    check("R7", "set beats clear", {31'b0, mode_err_o}, 32'd1);
    wr(3'd6, 32'h0);
    check("R7", "clear after", {31'b0, mode_err_o}, 32'd0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 6; i++) wr(3'(i), 32'h10 + 32'(i));
    fire(6'b11_1111);
    for (int i = 0; i < 6; i++) begin
      expect_raise("R8", 8'(8'h10 + i));
      if (i == 1) event_i = 6'b10_0000;   // re-fire while index 5 is pending
      cyc();
      event_i = '0;
    end
    check("R9", "merged, no extra raise", {31'b0, raise_vld_o}, 32'd0);
    expect_quiet("R9", 3);
  endtask

  task automatic t_late();
    // events for 3 and 4 on the same edge as a rewrite of entry 4
    reg_wr_i = 1'b1; reg_sel_i = 3'd4; reg_wdata_i = 32'h0000_0077;
    event_i = 6'b01_1000;
    cyc();
    reg_wr_i = 1'b0; event_i = '0;
    expect_raise("R10", 8'h13);
    cyc();
    expect_raise("R10", 8'h77);
    // mask entry 2 while it waits behind 0 and 1
    reg_wr_i = 1'b1; reg_sel_i = 3'd2; reg_wdata_i = 32'h0001_0012;
    event_i = 6'b00_0111;
    cyc();
    reg_wr_i = 1'b0; event_i = '0;
    expect_raise("R10", 8'h10);
    cyc();
    expect_raise("R10", 8'h11);
    cyc();
    check("R10", "masked before serve", {31'b0, raise_vld_o}, 32'd0);
    cyc();
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_masked();
    t_regs();
    t_forced();
    t_fixed();
    t_refuse();
    t_sticky();
    t_order();
    t_late();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule